// File: doc/BRIEF.md
# Vector Single-to-Bfloat16 Narrowing Unit

This block executes one SIMD narrowing conversion per accepted strobe. It receives a 32-bit instruction word, a 128-bit source vector holding four single-precision lanes, and the present contents of the 128-bit destination register. It first checks the instruction word against a fixed encoding. It then turns each of the four lanes into a 16-bit bfloat16 value and places the packed 64-bit result into one half of the destination.

A half-select bit in the instruction word picks the half. One setting writes the low half and clears the high half. The other writes the high half and leaves the low half as it was. Two control inputs stand in for the floating-point control register: one selects truncation instead of round-to-nearest-even, and one flushes subnormal inputs to zero.

The unit is fully registered. One cycle after a strobe it pulses a done flag and presents four things: the new destination value, whether the word was recognised, whether the operation was undefined because the bfloat16 feature was disabled, and whether an input subnormal was flushed. Register-file access and exception delivery belong to the surrounding pipeline.

Top module: `bf16_narrow_unit`

## Requirements
- R1: The word is recognised only when bit 31=0, bit 29=0 and bits 28:10 equal 0111010100001011010 (bits 28:24=01110, 23:22=10, 21:17=10000, 16:12=10110, 11:10=10). Bit 30 is the half-select bit, and bits 9:0 (two register indices) are ignored. An unrecognised word gives outMatch=0 and outUndef=0, and outDst equals dstPrev.
- R2: outValid is 1 exactly in the cycle after a cycle with inValid=1, and 0 otherwise. After reset, outValid, outMatch, outUndef and outDenorm are 0 and outDst is zero.
- R3: Source lane e is srcVec[32e+31:32e]. Its bfloat16 result lands in bits [16e+15:16e] of the 64-bit result, for e = 0..3.
- R4: With half-select 0, outDst[63:0] is the result and outDst[127:64] is zero.
- R5: With half-select 1, outDst[127:64] is the result and outDst[63:0] equals dstPrev[63:0].
- R6: A recognised word with featEn=0 gives outUndef=1, outDenorm=0, and outDst equal to dstPrev.
- R7: With rndZero=0, finite non-flushed inputs round to nearest, ties to even. The value equals the upper 16 bits of (x + 0x7FFF + x[16]), so the largest finite single becomes a signed infinity.
- R8: With rndZero=1, finite non-flushed inputs yield x[31:16].
- R9: A NaN input (exponent all ones, fraction non-zero) yields x[31:16] with result bit 6 forced to 1.
- R10: Infinities and zeros yield x[31:16], keeping their sign.
- R11: With flushEn=1, a subnormal input yields {sign, 15'b0}, and outDenorm=1 for that operation. With flushEn=0, subnormals round as in R7/R8 and outDenorm stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| instrWord | input | 32 | Instruction word to decode |
| srcVec | input | 128 | Four single-precision source lanes |
| dstPrev | input | 128 | Current destination register contents |
| featEn | input | 1 | Bfloat16 feature enable |
| rndZero | input | 1 | 1 = truncate, 0 = round to nearest even |
| flushEn | input | 1 | Flush subnormal inputs to signed zero |
| outValid | output | 1 | Done pulse, one cycle after inValid |
| outMatch | output | 1 | Word was recognised |
| outUndef | output | 1 | Recognised but feature disabled |
| outDenorm | output | 1 | A subnormal input was flushed |
| outDst | output | 128 | New destination value |

## Verification
Directed lanes separate the rounding paths. A tie with an even upper half must not round up, while a tie with an odd upper half must. The largest finite value must turn into infinity under nearest-even but not under truncation. Signalling and quiet NaNs, infinities and signed zeros must come out with the quiet bit set and their signs intact. Random vectors mix these classes with subnormals, both half-select settings on a non-zero prior destination, both control settings, feature-disabled cases and words with one fixed bit flipped, so that a lane swap, a wrong merge or a loose decode each changes the compared result.

// File: rtl/bf16n_pkg.sv
package bf16n_pkg;
  parameter int LANES = 4;
  parameter int SRC_W = 32;
  parameter int DST_W = 16;
  localparam int VEC_W  = LANES * SRC_W;
  localparam int HALF_W = LANES * DST_W;

  // fixed-bit decode: bits 9:0 are register indices, bit 30 selects the half
  localparam logic [31:0] DEC_MASK  = 32'hBFFF_FC00;
  localparam logic [31:0] DEC_VALUE = 32'h0EA1_6800;
  localparam int HALF_SEL_BIT = 30;

  typedef struct packed {
    logic load;       // an operation is accepted this cycle
    logic doConvert;  // recognised and enabled
    logic upperHalf;  // write the high half, keep the low half
    logic flush;      // flush subnormals
    logic rndZero;    // truncate instead of nearest-even
  } ctrlStrb_t;
endpackage

// File: rtl/bf16n_lane.sv
module bf16n_lane
  import bf16n_pkg::*;
(
  input  logic [SRC_W-1:0] inWord,
  input  logic             flush,
  input  logic             rndZero,
  output logic [DST_W-1:0] outHalf,
  output logic             denormHit
);
  localparam int EXP_W = 8;
  localparam int MAN_W = SRC_W - EXP_W - 1;
  localparam int CUT   = SRC_W - DST_W;

  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic             isNan, isInf, isSub, roundUp;
  logic [DST_W-1:0] upper;

  always_comb begin
    expField = inWord[SRC_W-2 -: EXP_W];
    manField = inWord[MAN_W-1:0];
    upper    = inWord[SRC_W-1:CUT];
    isNan    = (&expField) && (|manField);
    isInf    = (&expField) && !(|manField);
    isSub    = !(|expField) && (|manField);
    roundUp  = (inWord[CUT-1:0] > {1'b1, {(CUT-1){1'b0}}}) ||
               ((inWord[CUT-1:0] == {1'b1, {(CUT-1){1'b0}}}) && inWord[CUT]);
    denormHit = flush && isSub;
    if (isNan)               outHalf = upper | DST_W'(16'h0040);
    else if (isInf)          outHalf = upper;
    else if (denormHit)      outHalf = {inWord[SRC_W-1], {(DST_W-1){1'b0}}};
    else if (rndZero)        outHalf = upper;
    else                     outHalf = upper + DST_W'(roundUp);
  end
endmodule

// File: rtl/bf16n_ctrl.sv
module bf16n_ctrl
  import bf16n_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [31:0] instrWord,
  input  logic        featEn,
  input  logic        rndZero,
  input  logic        flushEn,
  output ctrlStrb_t   strb,
  output logic        outValid,
  output logic        outMatch,
  output logic        outUndef
);
  logic isMatch;

  always_comb begin
    isMatch        = (instrWord & DEC_MASK) == DEC_VALUE;
    strb.load      = inValid;
    strb.doConvert = inValid && isMatch && featEn;
    strb.upperHalf = instrWord[HALF_SEL_BIT];
    strb.flush     = flushEn;
    strb.rndZero   = rndZero;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outMatch <= 1'b0;
      outUndef <= 1'b0;
    end else begin
      outValid <= inValid;
      outMatch <= inValid && isMatch;
      outUndef <= inValid && isMatch && !featEn;
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  p_undef_needs_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outUndef |-> (outMatch && outValid));
  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && instrWord[31]) |=> !outMatch);
endmodule

// File: rtl/bf16n_datapath.sv
module bf16n_datapath
  import bf16n_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrb_t        strb,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] dstPrev,
  output logic [VEC_W-1:0] outDst,
  output logic             outDenorm
);
  logic [HALF_W-1:0] packed16;
  logic [LANES-1:0]  laneDen;
  logic [VEC_W-1:0]  merged;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    bf16n_lane u_lane (
      .inWord   (srcVec[e*SRC_W +: SRC_W]),
      .flush    (strb.flush),
      .rndZero  (strb.rndZero),
      .outHalf  (packed16[e*DST_W +: DST_W]),
      .denormHit(laneDen[e])
    );
  end

  always_comb begin
    if (!strb.doConvert)     merged = dstPrev;
    else if (strb.upperHalf) merged = {packed16, dstPrev[HALF_W-1:0]};
    else                     merged = {{(VEC_W-HALF_W){1'b0}}, packed16};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outDst    <= '0;
      outDenorm <= 1'b0;
    end else begin
      outDenorm <= strb.doConvert && (|laneDen);
      if (strb.load) outDst <= merged;
    end
  end

  p_upper_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doConvert && !strb.upperHalf) |=> (outDst[VEC_W-1:HALF_W] == '0));
  p_lower_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doConvert && strb.upperHalf) |=> (outDst[HALF_W-1:0] == $past(dstPrev[HALF_W-1:0])));
  p_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && !strb.doConvert) |=> (outDst == $past(dstPrev)));
  p_denorm_needs_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.flush || !strb.doConvert) |=> !outDenorm);
endmodule

// File: rtl/bf16_narrow_unit.sv
module bf16_narrow_unit
  import bf16n_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [31:0]      instrWord,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] dstPrev,
  input  logic             featEn,
  input  logic             rndZero,
  input  logic             flushEn,
  output logic             outValid,
  output logic             outMatch,
  output logic             outUndef,
  output logic             outDenorm,
  output logic [VEC_W-1:0] outDst
);
  ctrlStrb_t strb;

  bf16n_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .instrWord(instrWord),
    .featEn(featEn), .rndZero(rndZero), .flushEn(flushEn), .strb(strb),
    .outValid(outValid), .outMatch(outMatch), .outUndef(outUndef)
  );

  bf16n_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .srcVec(srcVec),
    .dstPrev(dstPrev), .outDst(outDst), .outDenorm(outDenorm)
  );
endmodule

// File: tb/bf16_narrow_unit_tb.sv
module bf16_narrow_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [127:0] srcVec = '0, dstPrev = '0, outDst;
  logic featEn = 1'b1, rndZero = 1'b0, flushEn = 1'b0;
  logic outValid, outMatch, outUndef, outDenorm;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  bf16_narrow_unit dut_i (.*);

  function automatic logic [15:0] refLane(input logic [31:0] x, input logic rz, input logic fl);
    logic [31:0] t;
    if (x[30:23] == 8'hFF && x[22:0] != 0) return x[31:16] | 16'h0040;
    if (x[30:23] == 8'hFF) return x[31:16];
    if (x[30:23] == 8'h00 && x[22:0] != 0 && fl) return {x[31], 15'h0};
    if (rz) return x[31:16];
    t = x + 32'h7FFF + {31'b0, x[16]};
    return t[31:16];
  endfunction

  function automatic logic refMatch(input logic [31:0] w);
    return (w[31] == 1'b0) && (w[29:10] == {1'b0, 5'b01110, 2'b10, 5'b10000, 5'b10110, 2'b10});
  endfunction

  function automatic logic [31:0] mkWord(input logic q);
    return {1'b0, q, 1'b0, 5'b01110, 2'b10, 5'b10000, 5'b10110, 2'b10, 10'($urandom)};
  endfunction

  function automatic logic [31:0] randLane();
    logic [31:0] r = $urandom;
    case ($urandom % 6)
      0: return r;
      1: return {r[31], 8'hFF, r[22:0] | 23'h1};
      2: return {r[31], ($urandom % 2) ? 8'hFE : 8'hFF, ($urandom % 2) ? 23'h7FFFFF : 23'h0};
      3: return {r[31], 8'h00, r[22:0] | 23'h1};
      4: return {r[31:16], 16'h8000};
      default: return {r[31], 31'h0};
    endcase
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one operation, sample one cycle later, compare against the model
  task automatic runOp(input string req, input logic [31:0] w, input logic [127:0] src,
                       input logic [127:0] prev, input logic fe, input logic rz, input logic fl);
    logic [63:0] res;
    logic den, m;
    logic [127:0] expDst;
    den = 1'b0;
    for (int e = 0; e < 4; e++) begin
      res[16*e +: 16] = refLane(src[32*e +: 32], rz, fl);
      if (fl && src[32*e+23 +: 8] == 8'h00 && src[32*e +: 23] != 0) den = 1'b1;
    end
    m = refMatch(w);
    if (!m || !fe) expDst = prev;
    else if (w[30]) expDst = {res, prev[63:0]};
    else expDst = {64'h0, res};
    inValid = 1'b1; instrWord = w; srcVec = src; dstPrev = prev;
    featEn = fe; rndZero = rz; flushEn = fl;
    @(negedge clk);
    inValid = 1'b0;
    chk({req, " R2 done"}, 128'(outValid), 128'(1));
    chk({req, " R1 match"}, 128'(outMatch), 128'(m));
    chk({req, " R6 undef"}, 128'(outUndef), 128'(m && !fe));
    chk({req, " R11 denorm"}, 128'(outDenorm), 128'(m && fe && den));
    chk({req, " R3 dst"}, outDst, expDst);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] prev, src;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R2 reset valid", 128'(outValid), 128'(0));
    chk("R2 reset dst", outDst, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle no done", 128'(outValid), 128'(0));

    prev = {4{32'hA5A5_5A5A}};
    src  = {32'h7F7F_FFFF, 32'h3F81_8000, 32'h3F80_8000, 32'h7F80_0001};
    // R7 ties, R7 max finite to inf, R9 signalling NaN, R4 low half
    runOp("R7 R9 R4", mkWord(1'b0), src, prev, 1'b1, 1'b0, 1'b0);
    chk("R7 literal", outDst, {64'h0, 16'h7F80, 16'h3F82, 16'h3F80, 16'h7FC0});
    // R8 truncation, R5 high half keeps low half
    runOp("R8 R5", mkWord(1'b1), src, prev, 1'b1, 1'b1, 1'b0);
    chk("R8 literal", outDst, {16'h7F7F, 16'h3F81, 16'h3F80, 16'h7FC0, prev[63:0]});
    // R10 infinities and signed zeros, R9 negative NaN
    src = {32'hFF80_0000, 32'h8000_0000, 32'h0000_0000, 32'hFF81_0000};
    runOp("R10", mkWord(1'b0), src, prev, 1'b1, 1'b0, 1'b0);
    chk("R10 literal", outDst, {64'h0, 16'hFF80, 16'h8000, 16'h0000, 16'hFFC1});
    // R11 flush vs no flush
    src = {32'h8001_2345, 32'h007F_FFFF, 32'h3F80_0000, 32'h0000_8000};
    runOp("R11 flush", mkWord(1'b0), src, prev, 1'b1, 1'b0, 1'b1);
    chk("R11 literal", outDst, {64'h0, 16'h8000, 16'h0000, 16'h3F80, 16'h0000});
    runOp("R11 noflush", mkWord(1'b0), src, prev, 1'b1, 1'b0, 1'b0);
    chk("R11 noflush literal", outDst, {64'h0, 16'h8001, 16'h0080, 16'h3F80, 16'h0000});
    // R6 feature disabled
    runOp("R6 disabled", mkWord(1'b0), src, prev, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R2 single pulse", 128'(outValid), 128'(0));

    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      for (int e = 0; e < 4; e++) src[32*e +: 32] = randLane();
      prev = {$urandom, $urandom, $urandom, $urandom};
      w = mkWord(1'($urandom));
      if ($urandom % 5 == 0) w[$urandom % 22 + 10] ^= 1'b1; // may flip half-select or a fixed bit (R1)
      runOp("random", w, src, prev, ($urandom % 8) != 0, 1'($urandom), 1'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule